// File: doc/BRIEF.md
# Branch Delay Slot Sequencer

This block is the program-counter sequencing logic of a 32-bit RISC core. Each cycle the decoder may present one instruction's control summary: whether it is a branch or return, whether that branch is taken, whether it has a delay slot, the branch target, and whether the instruction is a breakpoint, an immediate prefix or the halt encoding. The sequencer decides the next program counter and keeps three pieces of state: whether the instruction now being presented sits in a delay slot, whether an immediate prefix is active for it, and whether execution has stopped and why.

A taken branch with a delay slot first lets the instruction after the branch run, then moves to the target. A branch found in a delay slot is illegal and stops execution. A breakpoint in a delay slot is quietly treated as an ordinary instruction. The halt encoding stops with an exit code and a breakpoint elsewhere stops with a trap code. Once stopped, the PC and all flags hold until a restart pulse clears the stop condition; execution then resumes at the held PC.

The decode input is a valid/ready stream: an instruction is consumed on a cycle where `dec_valid` and `dec_ready` are both high. `dec_ready` is high exactly while no stop condition is recorded, so back-pressure is applied only while stopped; the decoder must hold its summary stable until it is accepted. The remaining pins are plain control and status.

Top module: `bds_sequencer`

## Requirements
- R1: `fetch_addr` always equals `cur_pc` with its two low bits forced to zero.
- R2: An accepted instruction that is not a taken branch moves `cur_pc` to `cur_pc + 4` on the next cycle; `dec_taken` has no effect when `dec_branch` is low.
- R3: An accepted taken branch without a delay slot loads `cur_pc` with `dec_target` and leaves `in_slot` low.
- R4: An accepted taken branch with a delay slot moves `cur_pc` to `cur_pc + 4` and sets `in_slot`; when the next instruction is accepted, `cur_pc` becomes the saved target and `in_slot` clears, so `in_slot` lasts exactly one instruction.
- R5: A branch (taken or not) accepted while `in_slot` is high sets `exc_code` to 3 (illegal), keeps `cur_pc` at the slot address, and clears `in_slot` and `prefix_active`.
- R6: A breakpoint accepted while `in_slot` is high raises nothing and completes the slot normally (`cur_pc` becomes the branch target).
- R7: A breakpoint accepted outside a delay slot sets `exc_code` to 1 (trap) and keeps `cur_pc`; it takes priority over a halt flag on the same instruction.
- R8: The halt encoding, in or out of a delay slot, sets `exc_code` to 2 (exit) and keeps `cur_pc`.
- R9: `prefix_active` is set after an accepted prefix instruction and cleared after any other accepted instruction that does not trap or exit (including a delay-slot instruction); trap and exit leave it unchanged.
- R10: While `exc_code` is nonzero, `dec_ready` is low, decode inputs are ignored and `cur_pc`, `in_slot`, `prefix_active` and `exc_code` hold.
- R11: `restart` while stopped clears `exc_code` and `in_slot` on the next cycle and execution resumes at the held `cur_pc`; `restart` while running has no effect.
- R12: After reset `cur_pc` is 0, `in_slot`, `prefix_active` and `exc_code` are 0 and `dec_ready` is 1.
- R13: A cycle without an accepted instruction leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode summary present |
| dec_ready | output | 1 | Sequencer can consume the summary |
| dec_branch | input | 1 | Instruction is a branch or return |
| dec_taken | input | 1 | Branch condition holds |
| dec_slot | input | 1 | Branch has a delay slot |
| dec_target | input | 32 | Branch target address |
| dec_brk | input | 1 | Instruction is a breakpoint |
| dec_prefix | input | 1 | Instruction is an immediate prefix |
| dec_halt | input | 1 | Instruction is the halt encoding |
| restart | input | 1 | Clear a stop condition and resume |
| fetch_addr | output | 32 | Word-aligned fetch address |
| cur_pc | output | 32 | Current program counter |
| in_slot | output | 1 | Presented instruction is in a delay slot |
| prefix_active | output | 1 | Immediate prefix applies to presented instruction |
| exc_code | output | 2 | 0 none, 1 trap, 2 exit, 3 illegal |

## Verification
The hardest situation to reach is an instruction arriving in a delay slot with a second control-flow flag on it: a branch (which must trap as illegal) or a breakpoint (which must vanish), possibly combined with a prefix or halt. Random stimulus makes taken branches with delay slots common so that slots appear often, and then sets the branch, breakpoint and halt flags with elevated probability on every instruction, so these slot combinations recur many times; a directed prologue also walks each of them once from known addresses, including an unaligned target to exercise the low-bit masking. A behavioural model in the bench is compared with every output each cycle, with restart pulses issued at random while stopped.

// File: rtl/bds_pkg.sv
package bds_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_TRAP = 2'd1,
    EXC_EXIT = 2'd2,
    EXC_ILL  = 2'd3
  } exc_e;

  typedef enum logic [2:0] {
    ACT_SEQ   = 3'd0,
    ACT_JUMP  = 3'd1,
    ACT_ENTER = 3'd2,
    ACT_LEAVE = 3'd3,
    ACT_TRAP  = 3'd4,
    ACT_EXIT  = 3'd5,
    ACT_ILL   = 3'd6
  } act_e;
endpackage

// File: rtl/bds_classify.sv
module bds_classify
  import bds_pkg::*;
(
  input  logic in_slot,
  input  logic is_branch,
  input  logic taken,
  input  logic has_slot,
  input  logic is_brk,
  input  logic is_halt,
  output act_e act
);
  always_comb begin
    if (in_slot) begin
      if (is_branch)    act = ACT_ILL;
      else if (is_halt) act = ACT_EXIT;
      else              act = ACT_LEAVE;
    end else begin
      if (is_brk)                  act = ACT_TRAP;
      else if (is_halt)            act = ACT_EXIT;
      else if (is_branch && taken) act = has_slot ? ACT_ENTER : ACT_JUMP;
      else                         act = ACT_SEQ;
    end
  end
endmodule

// File: rtl/bds_pc_unit.sv
module bds_pc_unit
  import bds_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          STEP     = 4,
  parameter int          LOW_BITS = 2,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  act_e          act,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] fetch_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_q, tgt_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (advance) begin
      case (act)
        ACT_SEQ, ACT_ENTER: pc_d = pc_q + STEP_V;
        ACT_JUMP:           pc_d = target;
        ACT_LEAVE:          pc_d = tgt_q;
        default:            pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC[AW-1:0];
      tgt_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (advance && act == ACT_ENTER) tgt_q <= target;
    end
  end

  assign pc_o    = pc_q;
  assign fetch_o = {pc_q[AW-1:LOW_BITS], {LOW_BITS{1'b0}}};

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && act == ACT_SEQ) |=> pc_q == $past(pc_q) + STEP_V);

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (act == ACT_TRAP || act == ACT_EXIT || act == ACT_ILL)) |=> $stable(pc_q));

  // R1
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o[LOW_BITS-1:0] == '0 && fetch_o[AW-1:LOW_BITS] == pc_o[AW-1:LOW_BITS]);
endmodule

// File: rtl/bds_flag_unit.sv
module bds_flag_unit
  import bds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  act_e act,
  input  logic is_prefix,
  input  logic restart,
  output logic slot_o,
  output logic pfx_o,
  output exc_e exc_o
);
  logic slot_q, pfx_q;
  exc_e exc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      pfx_q  <= 1'b0;
      exc_q  <= EXC_NONE;
    end else if (advance) begin
      slot_q <= (act == ACT_ENTER);
      case (act)
        ACT_TRAP: exc_q <= EXC_TRAP;
        ACT_EXIT: exc_q <= EXC_EXIT;
        ACT_ILL:  begin exc_q <= EXC_ILL; pfx_q <= 1'b0; end
        default:  pfx_q <= is_prefix;
      endcase
    end else if (restart && exc_q != EXC_NONE) begin
      exc_q  <= EXC_NONE;
      slot_q <= 1'b0;
    end
  end

  assign slot_o = slot_q;
  assign pfx_o  = pfx_q;
  assign exc_o  = exc_q;

  // R9
  pfx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !is_prefix && act != ACT_TRAP && act != ACT_EXIT) |=> !pfx_q);

  // R11
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && exc_q != EXC_NONE) |=> (exc_q == EXC_NONE && !slot_q));
endmodule

// File: rtl/bds_sequencer.sv
module bds_sequencer
  import bds_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic          dec_branch,
  input  logic          dec_taken,
  input  logic          dec_slot,
  input  logic [AW-1:0] dec_target,
  input  logic          dec_brk,
  input  logic          dec_prefix,
  input  logic          dec_halt,
  input  logic          restart,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] cur_pc,
  output logic          in_slot,
  output logic          prefix_active,
  output logic [1:0]    exc_code
);
  localparam int STEP     = 4;
  localparam int LOW_BITS = $clog2(STEP);

  act_e act;
  exc_e exc;
  logic accept;

  assign dec_ready = (exc == EXC_NONE);
  assign accept    = dec_valid && dec_ready;
  assign exc_code  = exc;

  bds_classify u_cls (
    .in_slot   (in_slot),
    .is_branch (dec_branch),
    .taken     (dec_taken),
    .has_slot  (dec_slot),
    .is_brk    (dec_brk),
    .is_halt   (dec_halt),
    .act       (act)
  );

  bds_pc_unit #(.AW(AW), .STEP(STEP), .LOW_BITS(LOW_BITS), .RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .act     (act),
    .target  (dec_target),
    .pc_o    (cur_pc),
    .fetch_o (fetch_addr)
  );

  bds_flag_unit u_flg (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (accept),
    .act       (act),
    .is_prefix (dec_prefix),
    .restart   (restart),
    .slot_o    (in_slot),
    .pfx_o     (prefix_active),
    .exc_o     (exc)
  );

  // R5
  slot_branch_ill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_slot && dec_branch) |=> exc_code == 2'd3);

  // R4
  slot_one_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_slot) |=> !in_slot);

  // R10
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code != 2'd0 && !restart) |=> ($stable(exc_code) && $stable(cur_pc) && $stable(prefix_active)));

  // R6
  slot_brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_slot && dec_brk && !dec_branch && !dec_halt) |=> exc_code == 2'd0);
endmodule

// File: tb/bds_sequencer_tb_top.sv
module bds_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_branch = 0, dec_taken = 0, dec_slot = 0;
  logic dec_brk = 0, dec_prefix = 0, dec_halt = 0, restart = 0;
  logic [31:0] dec_target = '0;
  logic dec_ready, in_slot, prefix_active;
  logic [31:0] fetch_addr, cur_pc;
  logic [1:0] exc_code;

  int total = 0, bad = 0;
  bit done = 0, started = 0;

  // behavioural model state
  logic [31:0] m_pc = 0, m_tgt = 0;
  bit m_slot = 0, m_pfx = 0;
  int m_exc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bds_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_branch(dec_branch), .dec_taken(dec_taken), .dec_slot(dec_slot),
    .dec_target(dec_target), .dec_brk(dec_brk), .dec_prefix(dec_prefix),
    .dec_halt(dec_halt), .restart(restart), .fetch_addr(fetch_addr),
    .cur_pc(cur_pc), .in_slot(in_slot), .prefix_active(prefix_active),
    .exc_code(exc_code)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_tgt = 0; m_slot = 0; m_pfx = 0; m_exc = 0;
    end else begin
      started = 1;
      if (m_exc != 0) begin
        if (restart) begin m_exc = 0; m_slot = 0; end
      end else if (dec_valid) begin
        if (m_slot) begin
          m_slot = 0;
          if (dec_branch) begin m_exc = 3; m_pfx = 0; end
          else if (dec_halt) m_exc = 2;
          else begin m_pc = m_tgt; m_pfx = dec_prefix; end
        end else if (dec_brk) m_exc = 1;
        else if (dec_halt) m_exc = 2;
        else begin
          m_pfx = dec_prefix;
          if (dec_branch && dec_taken && dec_slot) begin
            m_tgt = dec_target; m_pc = m_pc + 4; m_slot = 1;
          end else if (dec_branch && dec_taken) m_pc = dec_target;
          else m_pc = m_pc + 4;
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && started) begin
      check("R1 fetch_addr", fetch_addr, {m_pc[31:2], 2'b00});
      check("R2 cur_pc", cur_pc, m_pc);
      check("R4 in_slot", {31'd0, in_slot}, {31'd0, m_slot});
      check("R9 prefix_active", {31'd0, prefix_active}, {31'd0, m_pfx});
      check("R7 exc_code", {30'd0, exc_code}, m_exc);
      check("R10 dec_ready", {31'd0, dec_ready}, {31'd0, (m_exc == 0)});
    end
  end

  task automatic drive(bit v, bit br, bit tk, bit sl, logic [31:0] tg,
                       bit bk, bit px, bit hl, bit rs);
    dec_valid = v; dec_branch = br; dec_taken = tk; dec_slot = sl;
    dec_target = tg; dec_brk = bk; dec_prefix = px; dec_halt = hl; restart = rs;
    @(negedge clk);
  endtask

  task automatic plain(bit px); drive(1, 0, 0, 0, 32'h0, 0, px, 0, 0); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check("R12 pc", cur_pc, 32'h0);
    check("R12 flags", {29'd0, in_slot, prefix_active, (exc_code != 0)}, 32'h0);
    check("R12 ready", {31'd0, dec_ready}, 32'd1);
    drive(1, 0, 1, 1, 32'h500, 0, 0, 0, 0);          // R2 taken ignored
    check("R2 pc", cur_pc, 32'h4);
    drive(1, 1, 1, 0, 32'h100, 0, 0, 0, 0);          // R3
    check("R3 pc", cur_pc, 32'h100);
    check("R3 slot", {31'd0, in_slot}, 32'd0);
    plain(1);                                         // R9
    check("R9 set", {31'd0, prefix_active}, 32'd1);
    drive(1, 1, 1, 1, 32'h203, 0, 0, 0, 0);          // R4 enter
    check("R4 pc", cur_pc, 32'h108);
    check("R4 slot", {31'd0, in_slot}, 32'd1);
    plain(1);                                         // slot instr
    check("R4 target", cur_pc, 32'h203);
    check("R1 masked", fetch_addr, 32'h200);
    check("R9 slot pfx", {31'd0, prefix_active}, 32'd1);
    plain(0);
    check("R9 clear", {31'd0, prefix_active}, 32'd0);
    drive(1, 1, 1, 1, 32'h40, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 32'h0, 1, 0, 0, 0);            // R6 brk in slot
    check("R6 pc", cur_pc, 32'h40);
    check("R6 exc", {30'd0, exc_code}, 32'd0);
    drive(0, 1, 1, 0, 32'h999, 1, 1, 1, 0);          // R13 idle
    check("R13 pc", cur_pc, 32'h40);
    drive(1, 1, 1, 1, 32'h80, 0, 1, 0, 0);
    drive(1, 1, 0, 0, 32'h0, 0, 0, 0, 0);            // R5
    check("R5 exc", {30'd0, exc_code}, 32'd3);
    check("R5 pc", cur_pc, 32'h44);
    check("R5 slot", {31'd0, in_slot}, 32'd0);
    plain(0);                                         // R10 ignored
    check("R10 pc", cur_pc, 32'h44);
    drive(0, 0, 0, 0, 32'h0, 0, 0, 0, 1);            // R11
    check("R11 exc", {30'd0, exc_code}, 32'd0);
    plain(1);
    drive(1, 0, 0, 0, 32'h0, 1, 0, 1, 0);            // R7 brk over halt
    check("R7 exc", {30'd0, exc_code}, 32'd1);
    check("R7 pc", cur_pc, 32'h48);
    check("R9 trap keeps", {31'd0, prefix_active}, 32'd1);
    drive(0, 0, 0, 0, 32'h0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 32'h0, 0, 0, 1, 0);            // R8
    check("R8 exc", {30'd0, exc_code}, 32'd2);
    check("R8 pc", cur_pc, 32'h48);
    drive(0, 0, 0, 0, 32'h0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 32'h0, 0, 0, 0, 1);            // R11 restart while running
    check("R11 running", {cur_pc[29:0], exc_code}, {30'h48 >> 0, 2'd0} & 32'hFFFF_FFFF);
    for (int i = 0; i < 4000; i++) begin
      bit br = ($urandom_range(99) < 40);
      drive($urandom_range(99) < 85, br, $urandom_range(99) < 70,
            $urandom_range(99) < 60, $urandom, $urandom_range(99) < 8,
            $urandom_range(99) < 20, $urandom_range(99) < 4,
            $urandom_range(99) < 50);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule